// File: doc/BRIEF.md
# Core-Side Exclusive Reservation Monitor

This block keeps the per-core half of an exclusive-access protocol. A core issues four kinds of memory request: plain load, plain store, exclusive load and exclusive store. Every request carries an address and, for the exclusive kinds, a size selector. An exclusive load opens a reservation that records the exact address and access size. A later exclusive store is judged against that reservation, and the block reports a local pass or fail in the same cycle.

The core also supplies the answer from the system-level monitor. The block combines the two answers into a memory write enable and the status value that goes back to the destination register. Any plain access, whatever its address, drops the reservation. A synchronous clear input drops it as well, for example on an exception or a context switch. The reservation is a single entry with no address masking, so the stored address and size must match the store exactly.

Top module: `lmon_local_monitor`

## Requirements
- R1: After reset the monitor is open (`armed_o` = 0) and holds a tag of address 0 with size none, so an exclusive store to address 0 fails.
- R2: An exclusive load (`req_op_i` = 2) with a legal size selector arms the monitor on the next cycle and records its address and size. A later exclusive load replaces the record. Cycles with no request leave the record unchanged.
- R3: A plain load (`req_op_i` = 0) or plain store (`req_op_i` = 1) seen while armed opens the monitor on the next cycle, whatever its address.
- R4: An exclusive store (`req_op_i` = 3) while armed passes (`local_ok_o` = 1) only if its address equals the recorded address exactly and its size equals the recorded size. The monitor is open on the next cycle whether the store passes or fails.
- R5: An exclusive store while open fails locally, and the monitor stays open.
- R6: `wr_commit_o` is 1 only in the cycle of an exclusive store whose local check passes while `glob_ok_i` = 1. `status_o` is 0 in that case and 1 in every other cycle.
- R7: The size selector encodes word = 0, byte = 2 and halfword = 3; the value 1 is illegal. On an exclusive request with selector 1, `size_err_o` is 1 in that cycle. An exclusive store with selector 1 fails, and an exclusive load with selector 1 leaves the monitor open.
- R8: With `clear_i` = 1 the monitor is open on the next cycle. Clear wins over an exclusive load in the same cycle, and an exclusive store in the same cycle fails.
- R9: `local_ok_o`, `wr_commit_o`, `status_o` and `size_err_o` respond in the same cycle as the request. `size_err_o` stays 0 for plain requests and when `req_valid_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Synchronous reservation clear |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 plain load, 1 plain store, 2 exclusive load, 3 exclusive store |
| req_addr_i | input | ADDR_W | Request byte address |
| req_szsel_i | input | 2 | Size selector for exclusive requests |
| glob_ok_i | input | 1 | Pass answer from the system-level monitor |
| local_ok_o | output | 1 | Local pass for the current exclusive store |
| wr_commit_o | output | 1 | Memory write enable for the exclusive store |
| status_o | output | 1 | Status for the destination register: 0 pass, 1 fail |
| size_err_o | output | 1 | Illegal size selector on an exclusive request |
| armed_o | output | 1 | Reservation held |

## Verification
The clear input can arrive in the same cycle as a request, and this pairing is the main concern. The bench places `clear_i` alongside an exclusive load and alongside an exclusive store. A clear together with the load must leave the monitor open on the next cycle. A clear together with the store must drop `local_ok_o` and `wr_commit_o` at once, even though the tag matches. A separate clear with no request checks that clear alone drops a live reservation.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } lmon_size_e;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_XLOAD  = 2'd2,
        OP_XSTORE = 2'd3
    } lmon_op_e;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_EXCL = 1'b1
    } lmon_state_e;

    typedef struct packed {
        logic       plain;
        logic       xload;
        logic       xstore;
        logic       size_bad;
        lmon_size_e size;
    } lmon_req_t;

    // Selector 1 has no legal meaning and maps to SZ_NONE.
    function automatic lmon_size_e sel_to_size(input logic [1:0] sel);
        lmon_size_e s;
        case (sel)
            2'd0:    s = SZ_WORD;
            2'd2:    s = SZ_BYTE;
            2'd3:    s = SZ_HALF;
            default: s = SZ_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lmon_req_decode.sv
module lmon_req_decode
    import lmon_pkg::*;
(
    input  logic       valid_i,
    input  logic [1:0] op_i,
    input  logic [1:0] szsel_i,
    output lmon_req_t  req_o
);
    lmon_op_e   op;
    lmon_size_e sz;

    always_comb begin
        op = lmon_op_e'(op_i);
        sz = sel_to_size(szsel_i);
        req_o.plain    = valid_i && (op == OP_LOAD || op == OP_STORE);
        req_o.xload    = valid_i && (op == OP_XLOAD);
        req_o.xstore   = valid_i && (op == OP_XSTORE);
        req_o.size     = sz;
        req_o.size_bad = valid_i && (op == OP_XLOAD || op == OP_XSTORE) && (sz == SZ_NONE);
    end
endmodule

// File: rtl/lmon_reserve_reg.sv
module lmon_reserve_reg
    import lmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              arm_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  lmon_size_e        arm_size_i,
    output lmon_state_e       state_o,
    output logic [ADDR_W-1:0] tag_addr_o,
    output lmon_size_e        tag_size_o
);
    always_ff @(posedge clk) begin
        if (rst || drop_i) begin
            state_o    <= ST_OPEN;
            tag_addr_o <= '0;
            tag_size_o <= SZ_NONE;
        end else if (arm_i) begin
            state_o    <= ST_EXCL;
            tag_addr_o <= arm_addr_i;
            tag_size_o <= arm_size_i;
        end
    end

    // R8: a clear always leaves the reservation open.
    p_clear_opens_r8: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (state_o == ST_OPEN));

    // R2: arming records the requested address and size.
    p_arm_records_r2: assert property (@(posedge clk) disable iff (rst)
        (arm_i && !drop_i) |=> (state_o == ST_EXCL && tag_addr_o == $past(arm_addr_i)
                                && tag_size_o == $past(arm_size_i)));

    // R2: with no event the tag holds.
    p_tag_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!arm_i && !drop_i) |=> ($stable(tag_addr_o) && $stable(state_o)));
endmodule

// File: rtl/lmon_store_judge.sv
module lmon_store_judge
    import lmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  lmon_req_t         req_i,
    input  logic              clear_i,
    input  lmon_state_e       state_i,
    input  logic [ADDR_W-1:0] tag_addr_i,
    input  lmon_size_e        tag_size_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              local_ok_o
);
    logic addr_hit;
    logic size_hit;

    always_comb begin
        addr_hit   = (addr_i == tag_addr_i);
        size_hit   = (req_i.size == tag_size_i);
        local_ok_o = req_i.xstore && !clear_i && !req_i.size_bad
                     && (state_i == ST_EXCL) && addr_hit && size_hit;
    end

    // R7: an illegal size can never produce a local pass.
    always_comb begin
        if (req_i.size_bad) begin
            a_bad_size_no_pass_r7: assert (!local_ok_o);
        end
    end
endmodule

// File: rtl/lmon_local_monitor.sv
module lmon_local_monitor
    import lmon_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_szsel_i,
    input  logic              glob_ok_i,
    output logic              local_ok_o,
    output logic              wr_commit_o,
    output logic              status_o,
    output logic              size_err_o,
    output logic              armed_o
);
    lmon_req_t         req;
    lmon_state_e       state;
    logic [ADDR_W-1:0] tag_addr;
    lmon_size_e        tag_size;
    logic              arm;
    logic              drop;

    lmon_req_decode u_decode (
        .valid_i (req_valid_i),
        .op_i    (req_op_i),
        .szsel_i (req_szsel_i),
        .req_o   (req)
    );

    always_comb begin
        arm  = req.xload && !req.size_bad && !clear_i;
        drop = clear_i
            || ((state == ST_EXCL) && (req.plain || req.xstore))
            || (req.xload && req.size_bad);
    end

    lmon_reserve_reg #(.ADDR_W(ADDR_W)) u_reserve (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (clear_i),
        .arm_i      (arm),
        .drop_i     (drop),
        .arm_addr_i (req_addr_i),
        .arm_size_i (req.size),
        .state_o    (state),
        .tag_addr_o (tag_addr),
        .tag_size_o (tag_size)
    );

    lmon_store_judge #(.ADDR_W(ADDR_W)) u_judge (
        .req_i      (req),
        .clear_i    (clear_i),
        .state_i    (state),
        .tag_addr_i (tag_addr),
        .tag_size_i (tag_size),
        .addr_i     (req_addr_i),
        .local_ok_o (local_ok_o)
    );

    always_comb begin
        wr_commit_o = local_ok_o && glob_ok_i;
        status_o    = !wr_commit_o;
        size_err_o  = req.size_bad;
        armed_o     = (state == ST_EXCL);
    end

    // R3: any plain access drops the reservation.
    p_plain_drops_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && (req_op_i == 2'd0 || req_op_i == 2'd1)) |=> !armed_o);

    // R4: an exclusive store always consumes the reservation.
    p_xstore_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_op_i == 2'd3) |=> !armed_o);

    // R5: with no reservation an exclusive store cannot pass.
    p_open_store_fails_r5: assert property (@(posedge clk) disable iff (rst)
        (!armed_o && req_valid_i && req_op_i == 2'd3) |-> !local_ok_o);

    // R6: a committed write leaves the monitor open.
    p_commit_drops_r6: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |=> !armed_o);

    // R7: a size error blocks the write and leaves the monitor open.
    p_size_err_r7: assert property (@(posedge clk) disable iff (rst)
        size_err_o |-> (!wr_commit_o ##1 !armed_o));

    // R9: a size error needs an exclusive request.
    p_err_needs_excl_r9: assert property (@(posedge clk) disable iff (rst)
        size_err_o |-> (req_valid_i && req_op_i[1]));
endmodule

// File: tb/lmon_local_monitor_tb.sv
module lmon_local_monitor_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear_i = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_op_i = 2'd0;
    logic [AW-1:0] req_addr_i = '0;
    logic [1:0]    req_szsel_i = 2'd0;
    logic          glob_ok_i = 1'b0;
    logic          local_ok_o, wr_commit_o, status_o, size_err_o, armed_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lmon_local_monitor #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .clear_i(clear_i), .req_valid_i(req_valid_i),
        .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_szsel_i(req_szsel_i),
        .glob_ok_i(glob_ok_i), .local_ok_o(local_ok_o), .wr_commit_o(wr_commit_o),
        .status_o(status_o), .size_err_o(size_err_o), .armed_o(armed_o)
    );

    typedef struct packed {
        logic        clr;
        logic        vld;
        logic [1:0]  op;
        logic [15:0] addr;
        logic [1:0]  sel;
        logic        glob;
        logic        ok;
        logic        com;
        logic        err;
        logic        arm;
        logic [3:0]  rq;
    } vec_t;

    // op: 0 load, 1 store, 2 excl load, 3 excl store; sel: 0 word, 2 byte, 3 half, 1 illegal
    localparam vec_t VECS [0:27] = '{
        '{1'b0,1'b1,2'd3,16'h0000,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 tag 0 does not match
        '{1'b0,1'b1,2'd2,16'h0100,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2}, // R2 arm word
        '{1'b0,1'b1,2'd3,16'h0100,2'd0,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd4}, // R4 pass
        '{1'b0,1'b1,2'd3,16'h0100,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd5}, // R5 open store fails
        '{1'b0,1'b1,2'd2,16'h0200,2'd2,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2}, // R2 arm byte
        '{1'b0,1'b1,2'd3,16'h0200,2'd3,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd4}, // R4 size mismatch
        '{1'b0,1'b1,2'd2,16'h0300,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2}, // R2 arm half
        '{1'b0,1'b1,2'd3,16'h0301,2'd3,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd4}, // R4 address off by one
        '{1'b0,1'b1,2'd2,16'h0400,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b1,2'd0,16'h9999,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 plain load elsewhere
        '{1'b0,1'b1,2'd2,16'h0400,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b1,2'd1,16'h1234,2'd1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 plain store, R9 no err
        '{1'b0,1'b1,2'd2,16'h0500,2'd2,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b1,2'd3,16'h0500,2'd2,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd6}, // R6 global refuses
        '{1'b0,1'b1,2'd2,16'h0600,2'd1,1'b0, 1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 illegal load size
        '{1'b0,1'b1,2'd2,16'h0600,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b1,2'd2,16'h0700,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2}, // R2 replace
        '{1'b0,1'b1,2'd3,16'h0600,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 old tag gone
        '{1'b0,1'b1,2'd2,16'h0800,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b1,2'd3,16'h0800,2'd1,1'b1, 1'b0,1'b0,1'b1,1'b0, 4'd7}, // R7 illegal store size
        '{1'b1,1'b1,2'd2,16'h0900,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd8}, // R8 clear beats load
        '{1'b0,1'b1,2'd2,16'h0A00,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b1,1'b1,2'd3,16'h0A00,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd8}, // R8 clear kills store
        '{1'b0,1'b1,2'd2,16'h0B00,2'd2,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b0,1'b0,2'd3,16'h0000,2'd1,1'b1, 1'b0,1'b0,1'b0,1'b1, 4'd9}, // R9 idle, no err
        '{1'b0,1'b1,2'd3,16'h0B00,2'd2,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd6}, // R6 commit
        '{1'b0,1'b1,2'd2,16'h0000,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b1, 4'd2},
        '{1'b1,1'b0,2'd0,16'h0000,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0, 4'd8}  // R8 clear alone
    };

    task automatic chk(input string what, input int rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%0b expected=%0b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic clr, input logic vld, input logic [1:0] op,
                         input logic [AW-1:0] addr, input logic [1:0] sel, input logic glob);
        @(negedge clk);
        clear_i = clr; req_valid_i = vld; req_op_i = op;
        req_addr_i = addr; req_szsel_i = sel; glob_ok_i = glob;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("armed after reset", 1, armed_o, 1'b0);
        chk("status idle", 6, status_o, 1'b1);
        chk("commit idle", 6, wr_commit_o, 1'b0);

        for (int i = 0; i < 28; i++) begin
            drive(VECS[i].clr, VECS[i].vld, VECS[i].op, {16'h0, VECS[i].addr},
                  VECS[i].sel, VECS[i].glob);
            #1;
            chk("local_ok", VECS[i].rq, local_ok_o, VECS[i].ok);
            chk("commit", VECS[i].rq, wr_commit_o, VECS[i].com);
            chk("status", VECS[i].rq, status_o, !VECS[i].com);
            chk("size_err", VECS[i].rq, size_err_o, VECS[i].err);
            @(posedge clk);
            #1;
            chk("armed next", VECS[i].rq, armed_o, VECS[i].arm);
        end

        // R1: reset while armed reopens and restores the zero tag
        drive(1'b0, 1'b1, 2'd2, 32'h0000_0C00, 2'd0, 1'b0);
        @(posedge clk); #1;
        chk("armed before reset", 2, armed_o, 1'b1);
        @(negedge clk);
        req_valid_i = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        chk("armed after mid reset", 1, armed_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b1, 2'd3, 32'h0000_0C00, 2'd0, 1'b1);
        #1;
        chk("store after reset", 1, local_ok_o, 1'b0);
        chk("commit after reset", 1, wr_commit_o, 1'b0);

        // R4: full-width address mismatch in the upper bits
        drive(1'b0, 1'b1, 2'd2, 32'h8000_0040, 2'd0, 1'b0);
        drive(1'b0, 1'b1, 2'd3, 32'h0000_0040, 2'd0, 1'b1);
        #1;
        chk("upper addr mismatch", 4, local_ok_o, 1'b0);
        drive(1'b0, 1'b0, 2'd0, 32'h0, 2'd0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule